// File: doc/BRIEF.md
# Hit-Driven Conversion and Selective Serial Readout Sequencer

This controller sits at the top of a multichannel front-end. It waits until one or more channels report a hit. It then captures that set of hit channels and asks the faster conversion domain to digitize them. When conversion has finished, it sends one serial record for each captured channel and returns to idle. Channels without a hit produce no record. Acquisition keeps running the whole time: a hit that arrives during a cycle is not lost, and it is served by a later cycle.

The block also contains a free-running coarse timestamp counter. The counter runs in the same slow clock domain as the serial output and feeds coarse time to the acquisition logic. Per-channel results are held in an external register file. The block addresses that file with a channel index and reads the channel's stored timestamp, charge and time values.

The FSM has six states:
- **IDLE**: waits for a hit. Any hit captures the hit set and moves to **REQ**.
- **REQ**: raises the conversion request. When the synchronized done is seen high, it moves to **REL**.
- **REL**: drops the request. When done is seen low again, it moves to **SCAN**.
- **SCAN**: if no captured channel remains, returns to **IDLE**. Otherwise it selects the lowest remaining channel, clears it from the captured set and moves to **LOAD**.
- **LOAD**: loads the Gray-coded record into the shifter and moves to **SHIFT**.
- **SHIFT**: sends one bit per cycle. After the last bit it moves back to **SCAN**.

Top module: `hit_readout_seq`

## Requirements
- R1: While reset is asserted, `conv_req_o`, `sframe_o`, `sstrobe_o` and `rel_o` are low and `ts_o` is zero.
- R2: `ts_o` increases by exactly one on every clock after reset, modulo 2^TS_W.
- R3: From IDLE, any set bit of `hit_i` starts a cycle and raises `conv_req_o`. The request stays high until `conv_done_i`, after two synchronizing flops, is seen high. No record starts until the request is low and done has returned low. `conv_req_o` is never high while a record is being sent.
- R4: A cycle emits records only for channels whose hit bit was set when the cycle started. The records go out in ascending channel index.
- R5: A record is 52 bits, sent most significant bit first. Bits 51:48 hold the Gray-coded channel index. Bits 47:24 hold the Gray-coded timestamp. Bits 23:12 hold the Gray-coded charge. Bits 11:0 hold the Gray-coded time. Each field is converted separately as g = b ^ (b >> 1).
- R6: `sframe_o` is high for exactly 52 consecutive cycles per record. `sstrobe_o` is high only in the record's first bit cycle. `rd_ch_o` holds the record's channel from the load cycle until the last bit.
- R7: `rel_o` pulses in the last bit cycle of each record, with `rd_ch_o` naming the channel just sent.
- R8: A hit that arrives after a cycle has started is not read in that cycle. It is read by a later cycle, and every cycle ends back in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout and timestamp clock |
| rst_n | input | 1 | Active-low reset |
| hit_i | input | NCH | Per-channel hit flags, held by acquisition until released |
| ts_o | output | TS_W | Free-running binary coarse timestamp |
| conv_req_o | output | 1 | Conversion request to the fast domain (level) |
| conv_done_i | input | 1 | Conversion done from the fast domain (level, asynchronous) |
| rd_ch_o | output | CH_W | Channel index into the result register file |
| rd_ts_i | input | TS_W | Stored coarse timestamp of `rd_ch_o` |
| rd_q_i | input | Q_W | Converted charge of `rd_ch_o` |
| rd_t_i | input | T_W | Converted fine time of `rd_ch_o` |
| sdata_o | output | 1 | Serial record data, MSB first |
| sstrobe_o | output | 1 | First-bit marker of a record |
| sframe_o | output | 1 | High while a record's bits are on `sdata_o` |
| rel_o | output | 1 | Channel-released pulse on the last bit |

## Verification
The hardest situation to reach from the ports is a hit that lands while a cycle is already sending records. That hit must be left out of the current cycle and then served on its own. The stimulus waits for `sframe_o` of the first record, then raises a new channel's hit, and expects that record after the whole batch, behind a second conversion handshake. A full batch of all sixteen channels exercises back-to-back records and the ascending scan across the full index range.

// File: rtl/hrs_pkg.sv
`timescale 1ns/1ps
package hrs_pkg;
    typedef enum logic [2:0] {
        IDLE_S,
        REQ_S,
        REL_S,
        SCAN_S,
        LOAD_S,
        SHIFT_S
    } seq_state_t;
endpackage

// File: rtl/hrs_sync2.sv
`timescale 1ns/1ps
module hrs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/hrs_tstamp.sv
`timescale 1ns/1ps
module hrs_tstamp #(
    parameter int TS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_o <= '0;
        else        ts_o <= ts_o + 1'b1;
    end
endmodule

// File: rtl/hrs_gray.sv
`timescale 1ns/1ps
module hrs_gray #(
    parameter int W = 12
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/hrs_lowpick.sv
`timescale 1ns/1ps
module hrs_lowpick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  mask_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
        any_o = |mask_i;
    end
endmodule

// File: rtl/hit_readout_seq.sv
`timescale 1ns/1ps
module hit_readout_seq #(
    parameter int NCH  = 16,
    parameter int CH_W = 4,
    parameter int TS_W = 24,
    parameter int Q_W  = 12,
    parameter int T_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  hit_i,
    output logic [TS_W-1:0] ts_o,
    output logic            conv_req_o,
    input  logic            conv_done_i,
    output logic [CH_W-1:0] rd_ch_o,
    input  logic [TS_W-1:0] rd_ts_i,
    input  logic [Q_W-1:0]  rd_q_i,
    input  logic [T_W-1:0]  rd_t_i,
    output logic            sdata_o,
    output logic            sstrobe_o,
    output logic            sframe_o,
    output logic            rel_o
);
    import hrs_pkg::*;

    localparam int REC_W = CH_W + TS_W + Q_W + T_W;
    localparam int CNT_W = $clog2(REC_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REC_W - 1);

    seq_state_t        state_q, state_d;
    logic [NCH-1:0]    pend_q;
    logic [REC_W-1:0]  shreg_q;
    logic [CNT_W-1:0]  bit_q;
    logic [CH_W-1:0]   ch_q;
    logic              done_s;
    logic              pick_any;
    logic [CH_W-1:0]   pick_idx;
    logic [CH_W-1:0]   g_ch;
    logic [TS_W-1:0]   g_ts;
    logic [Q_W-1:0]    g_q;
    logic [T_W-1:0]    g_t;

    hrs_tstamp #(.TS_W(TS_W)) u_ts (.clk(clk), .rst_n(rst_n), .ts_o(ts_o));
    hrs_sync2 u_sync (.clk(clk), .rst_n(rst_n), .async_i(conv_done_i), .sync_o(done_s));
    hrs_lowpick #(.N(NCH), .IW(CH_W)) u_pick (
        .mask_i(pend_q), .any_o(pick_any), .idx_o(pick_idx));

    hrs_gray #(.W(CH_W)) u_gch (.bin_i(ch_q),    .gray_o(g_ch));
    hrs_gray #(.W(TS_W)) u_gts (.bin_i(rd_ts_i), .gray_o(g_ts));
    hrs_gray #(.W(Q_W))  u_gq  (.bin_i(rd_q_i),  .gray_o(g_q));
    hrs_gray #(.W(T_W))  u_gt  (.bin_i(rd_t_i),  .gray_o(g_t));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE_S;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_S:  if (|hit_i)  state_d = REQ_S;
            REQ_S:   if (done_s)  state_d = REL_S;
            REL_S:   if (!done_s) state_d = SCAN_S;
            SCAN_S:  state_d = pick_any ? LOAD_S : IDLE_S;
            LOAD_S:  state_d = SHIFT_S;
            SHIFT_S: if (bit_q == LAST_BIT) state_d = SCAN_S;
            default: state_d = IDLE_S;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            shreg_q <= '0;
            bit_q   <= '0;
            ch_q    <= '0;
        end else begin
            unique case (state_q)
                IDLE_S: if (|hit_i) pend_q <= hit_i;
                SCAN_S: if (pick_any) begin
                    ch_q             <= pick_idx;
                    pend_q[pick_idx] <= 1'b0;
                end
                LOAD_S: begin
                    shreg_q <= {g_ch, g_ts, g_q, g_t};
                    bit_q   <= '0;
                end
                SHIFT_S: begin
                    shreg_q <= {shreg_q[REC_W-2:0], 1'b0};
                    bit_q   <= bit_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        conv_req_o = (state_q == REQ_S);
        sframe_o   = (state_q == SHIFT_S);
        sstrobe_o  = sframe_o && (bit_q == '0);
        rel_o      = sframe_o && (bit_q == LAST_BIT);
        sdata_o    = sframe_o && shreg_q[REC_W-1];
        rd_ch_o    = ch_q;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !done_s) |=> conv_req_o);
    // R3
    no_req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sframe_o |-> !conv_req_o);
    // R2
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ts_o == $past(ts_o) + 1'b1));
    // R6
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sframe_o) |-> sstrobe_o);
    // R6
    ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sframe_o && $past(sframe_o)) |-> $stable(rd_ch_o));
    // R7
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sframe_o) |-> $past(rel_o));
endmodule

// File: tb/hit_readout_seq_tb_top.sv
`timescale 1ns/1ps
module hit_readout_seq_tb_top;
    localparam int NCH = 16;
    localparam int CH_W = 4;
    localparam int TS_W = 24;
    localparam int Q_W = 12;
    localparam int T_W = 12;
    localparam int MAXCYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] hit_i = '0;
    logic [TS_W-1:0] ts_o;
    logic conv_req_o;
    logic conv_done_i = 1'b0;
    logic [CH_W-1:0] rd_ch_o;
    logic [TS_W-1:0] rd_ts_i;
    logic [Q_W-1:0] rd_q_i;
    logic [T_W-1:0] rd_t_i;
    logic sdata_o, sstrobe_o, sframe_o, rel_o;

    logic [TS_W-1:0] m_ts [NCH];
    logic [Q_W-1:0]  m_q  [NCH];
    logic [T_W-1:0]  m_t  [NCH];

    logic [51:0] exp_q [$];
    logic [3:0]  exp_ch [$];
    int compared = 0;
    int mismatched = 0;
    int conv_seen = 0;
    int conv_expect = 0;
    int cyc = 0;
    int nbits = 0;
    int dly = 0;
    logic [51:0] word = '0;
    logic prev_req = 1'b0;

    always #2.5 clk = ~clk;

    assign rd_ts_i = m_ts[rd_ch_o];
    assign rd_q_i  = m_q[rd_ch_o];
    assign rd_t_i  = m_t[rd_ch_o];

    hit_readout_seq #(.NCH(NCH), .CH_W(CH_W), .TS_W(TS_W), .Q_W(Q_W), .T_W(T_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ts_o(ts_o),
        .conv_req_o(conv_req_o), .conv_done_i(conv_done_i), .rd_ch_o(rd_ch_o),
        .rd_ts_i(rd_ts_i), .rd_q_i(rd_q_i), .rd_t_i(rd_t_i),
        .sdata_o(sdata_o), .sstrobe_o(sstrobe_o), .sframe_o(sframe_o), .rel_o(rel_o));

    function automatic logic [51:0] mkrec(input int c);
        logic [3:0] ch;
        ch = 4'(c);
        return {ch ^ (ch >> 1), m_ts[c] ^ (m_ts[c] >> 1),
                m_q[c] ^ (m_q[c] >> 1), m_t[c] ^ (m_t[c] >> 1)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input int c, input int seed);
        m_ts[c] = 24'(c * 7919 + seed * 104729 + 24'h5A5A5);
        m_q[c]  = 12'(c * 263 + seed * 97 + 12'hA3C);
        m_t[c]  = 12'(c * 151 + seed * 31 + 12'h3F1);
    endtask

    // driver: loads data, pushes expected records in ascending order, raises hits
    task automatic run_batch(input logic [NCH-1:0] hits, input int seed);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (hits[c]) begin
                fill(c, seed);
                exp_q.push_back(mkrec(c));
                exp_ch.push_back(4'(c));
            end
        end
        conv_expect++;
        hit_i = hit_i | hits;
    endtask

    task automatic wait_drain();
        wait (exp_q.size() == 0);
        repeat (10) @(posedge clk);
    endtask

    // conversion-domain model and hit release (acquisition model)
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_req_o && !prev_req) conv_seen++;
            prev_req = conv_req_o;
            if (conv_req_o && !conv_done_i) begin
                if (dly == 3) conv_done_i = 1'b1;
                else dly++;
            end else if (!conv_req_o) begin
                conv_done_i = 1'b0;
                dly = 0;
            end
            if (rel_o) hit_i[rd_ch_o] = 1'b0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst_n && sframe_o) begin
            if (sstrobe_o) begin
                nbits = 0;
                word = '0;
                // R3: handshake completed before the first bit
                check(!conv_req_o && !conv_done_i, "R3 handshake done before record",
                      {conv_req_o, conv_done_i}, 0);
            end
            word = {word[50:0], sdata_o};
            nbits++;
            if (rel_o) begin
                // R6: 52 bits per frame
                check(nbits == 52, "R6 frame length", nbits, 52);
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected record", word, 0);
                end else begin
                    logic [51:0] e;
                    logic [3:0]  ec;
                    e = exp_q.pop_front();
                    ec = exp_ch.pop_front();
                    // R4/R5: order and record content
                    check(word == e, "R5 record content/order R4", word, e);
                    // R7: release names channel
                    check(rd_ch_o == ec, "R7 release channel", rd_ch_o, ec);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > MAXCYC) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAXCYC);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [TS_W-1:0] t0;
        repeat (3) @(negedge clk);
        // R1
        check(conv_req_o == 0 && sframe_o == 0 && sstrobe_o == 0 && rel_o == 0,
              "R1 reset outputs", {conv_req_o, sframe_o, sstrobe_o, rel_o}, 0);
        check(ts_o == 0, "R1 reset timestamp", ts_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t0 = ts_o;
        @(negedge clk);
        // R2
        check(ts_o == t0 + 1, "R2 timestamp step", ts_o, t0 + 1);
        repeat (9) @(negedge clk);
        check(ts_o == t0 + 10, "R2 timestamp run", ts_o, t0 + 10);

        run_batch(16'h0001, 1); wait_drain();
        run_batch(16'h8000, 2); wait_drain();
        run_batch(16'h0A50, 3); wait_drain();
        run_batch(16'hFFFF, 4); wait_drain();

        // R8: hit arriving during readout waits for a later cycle
        run_batch(16'h0003, 5);
        wait (sframe_o);
        @(negedge clk);
        fill(9, 6);
        exp_q.push_back(mkrec(9));
        exp_ch.push_back(4'd9);
        conv_expect++;
        hit_i[9] = 1'b1;
        wait_drain();

        // R4: no stray records and one handshake per cycle; R8: back in idle
        check(exp_q.size() == 0, "R4 all expected records seen", exp_q.size(), 0);
        check(conv_seen == conv_expect, "R3/R8 conversion cycles", conv_seen, conv_expect);
        repeat (20) @(negedge clk);
        check(!conv_req_o && !sframe_o, "R8 idle after drain", {conv_req_o, sframe_o}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule